// File: doc/BRIEF.md
# HDLC Channel Control Register

This block is the control register for one HDLC channel. Software reaches it through a plain write port and a combinational read port. The block drives the reset strobes for the transmit path, the receive path and the two DMA engines. It also drives the transmit, receive and DMA-transmit enables to those blocks. A second address holds a sticky status flag that records an aborted DMA transmission.

The block is more than a passive store, because the DMA-transmit enable is watched by hardware. Four conditions clear it automatically: a transmit underrun, a loss of clear-to-send, a null next-descriptor pointer, and a descriptor not owned by DMA while the stop-on-skip setting is on. While the enable is set, the block masks the interrupt that would otherwise ask for transmit FIFO refills. On an underrun it requests an abort sequence from the framer. On a clear-to-send loss it holds the serial output high until clear-to-send returns low.

The block also shapes the transmit line. The line stays high while the transmitter is disabled. The framer is told to send idle fill whenever the transmitter is enabled and has nothing queued. Loads into the transmit FIFO are gated by the transmit enable.

Top module: `hdlc_chan_ctrl`

## Requirements
- R1: After reset the control register, the abort flag and every strobe, enable, request and interrupt output are 0, and the transmit line is 1.
- R2: A write to CTRL_OFS stores transmit enable from data bit 4, receive enable from bit 5 and DMA-transmit enable from bit 6. A read of CTRL_OFS returns those three bits in the same positions and 0 in all other bits. A read of any unmapped address returns 0.
- R3: Data bits 0, 1, 2 and 3 of a control write (transmit, receive, DMA-transmit and DMA-receive reset) each produce a pulse on the matching reset output for exactly the one cycle after the write. Written zeros produce no pulse.
- R4: While transmit enable is 0, the transmit line is 1 and a FIFO load request is refused. While transmit enable is 1, a load request is accepted in the same cycle.
- R5: The idle-fill request is 1 exactly when transmit enable is 1, no data is pending and the line is not forced high by clear-to-send loss.
- R6: The receive enable output, which gates flag detection, follows the stored receive-enable bit.
- R7: The transmit-FIFO-available interrupt passes through only while DMA-transmit enable is 0.
- R8: DMA-transmit enable reads 0 in the cycle after any of these is seen at a clock edge: underrun, clear-to-send high, null next pointer, or a not-DMA-owned descriptor with stop-on-skip on. This holds even when the same edge carries a control write that sets the bit.
- R9: An underrun seen while DMA-transmit enable is 1 raises the abort request for exactly the next cycle and sets the abort flag.
- R10: Clear-to-send high seen while DMA-transmit enable is 1 sets the abort flag. From the next cycle the transmit line stays 1 for as long as clear-to-send stays high.
- R11: The abort flag is bit 0 at STAT_OFS and is also output directly. Writing 1 to that bit clears it, writing 0 has no effect, and a same-cycle set wins over the clear.
- R12: While the transmitter is enabled and the line is not forced, the transmit line follows the framer's serial data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr |
| txUnderrun | input | 1 | Transmit FIFO underrun from the framer |
| ctsLine | input | 1 | Clear-to-send level, high means lost |
| nullNextDesc | input | 1 | Next descriptor pointer is null |
| descOwnedByDma | input | 1 | Current descriptor ownership bit |
| stopOnSkip | input | 1 | Stop when a descriptor is not DMA-owned |
| txFifoAvail | input | 1 | Transmit FIFO has room |
| txLoadReq | input | 1 | Request to load the transmit FIFO |
| txDataPending | input | 1 | Framer has data queued |
| txSerial | input | 1 | Serial data from the framer |
| txRst | output | 1 | Transmit path reset pulse |
| rxRst | output | 1 | Receive path reset pulse |
| dmaTxRst | output | 1 | DMA transmit reset pulse |
| dmaRxRst | output | 1 | DMA receive reset pulse |
| txEnOut | output | 1 | Transmitter enable |
| rxEnOut | output | 1 | Receiver and flag-detect enable |
| dmaTxEnOut | output | 1 | DMA transmit enable |
| txFifoIrq | output | 1 | Gated transmit-FIFO-available interrupt |
| txLoadOk | output | 1 | FIFO load accepted |
| txIdle | output | 1 | Send idle fill |
| txLine | output | 1 | Transmit serial output |
| abortReq | output | 1 | One-cycle abort sequence request |
| abortFlag | output | 1 | DMA transmit abort status |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=16, CTRL_OFS=0 and STAT_OFS=8. The narrower data word still leaves nine bits above the mapped field, so the test can show that those bits always read 0. The small address space makes it cheap to hit both mapped offsets and an unmapped one. With these settings the bench can cover each of the four auto-clear causes on its own, the write-versus-clear race on the DMA enable, and the set-versus-clear race on the abort flag. It also covers the full clear-to-send hold and release sequence.

// File: rtl/hdlc_ctrl_pkg.sv
package hdlc_ctrl_pkg;
  // bit positions in the control word
  localparam int BitTxRst    = 0;
  localparam int BitRxRst    = 1;
  localparam int BitDmaTxRst = 2;
  localparam int BitDmaRxRst = 3;
  localparam int BitTxEn     = 4;
  localparam int BitRxEn     = 5;
  localparam int BitDmaTxEn  = 6;
  localparam int NumRstBits  = 4;
  localparam int CtrlBits    = 7;
  // bit position in the status word
  localparam int BitAbort    = 0;

  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic rdCtrl;
    logic rdStat;
    logic dmaTxKill;
    logic abortSet;
  } ctrlStrb_t;
endpackage

// File: rtl/hdlc_ctrl_ctl.sv
module hdlc_ctrl_ctl
  import hdlc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              dmaTxEn,
  input  logic              txUnderrun,
  input  logic              ctsLine,
  input  logic              nullNextDesc,
  input  logic              descOwnedByDma,
  input  logic              stopOnSkip,
  output ctrlStrb_t         strb,
  output logic              abortReq,
  output logic              ctsForced
);
  logic ctsHold;
  logic hitCtrl, hitStat, skipStop;

  assign hitCtrl  = (addr == CTRL_OFS);
  assign hitStat  = (addr == STAT_OFS);
  assign skipStop = stopOnSkip & ~descOwnedByDma;

  always_comb begin
    strb.wrCtrl    = wrEn & hitCtrl;
    strb.wrStat    = wrEn & hitStat;
    strb.rdCtrl    = hitCtrl;
    strb.rdStat    = hitStat;
    strb.dmaTxKill = txUnderrun | ctsLine | nullNextDesc | skipStop;
    strb.abortSet  = dmaTxEn & (txUnderrun | ctsLine);
  end

  // hold is armed by a clear-to-send loss during DMA transmit, drops with CTS
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctsHold  <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      ctsHold  <= ctsLine & (ctsHold | dmaTxEn);
      abortReq <= dmaTxEn & txUnderrun;
    end
  end

  assign ctsForced = ctsHold & ctsLine;
endmodule

// File: rtl/hdlc_ctrl_dp.sv
module hdlc_ctrl_dp
  import hdlc_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [CtrlBits-1:0]   wrBits,
  output logic [DATA_W-1:0]     rdData,
  output logic [NumRstBits-1:0] rstPulse,
  output logic                  txEn,
  output logic                  rxEn,
  output logic                  dmaTxEn,
  output logic                  abortFlag
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPulse  <= '0;
      txEn      <= 1'b0;
      rxEn      <= 1'b0;
      dmaTxEn   <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      rstPulse <= strb.wrCtrl ? wrBits[NumRstBits-1:0] : '0;
      if (strb.wrCtrl) begin
        txEn <= wrBits[BitTxEn];
        rxEn <= wrBits[BitRxEn];
      end
      // hardware clear takes priority over a software set
      if (strb.dmaTxKill)   dmaTxEn <= 1'b0;
      else if (strb.wrCtrl) dmaTxEn <= wrBits[BitDmaTxEn];
      // set takes priority over write-one-to-clear
      abortFlag <= strb.abortSet |
                   (abortFlag & ~(strb.wrStat & wrBits[BitAbort]));
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdCtrl) begin
      rdData[BitTxEn]    = txEn;
      rdData[BitRxEn]    = rxEn;
      rdData[BitDmaTxEn] = dmaTxEn;
    end else if (strb.rdStat) begin
      rdData[BitAbort] = abortFlag;
    end
  end
endmodule

// File: rtl/hdlc_chan_ctrl.sv
module hdlc_chan_ctrl
  import hdlc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              txUnderrun,
  input  logic              ctsLine,
  input  logic              nullNextDesc,
  input  logic              descOwnedByDma,
  input  logic              stopOnSkip,
  input  logic              txFifoAvail,
  input  logic              txLoadReq,
  input  logic              txDataPending,
  input  logic              txSerial,
  output logic              txRst,
  output logic              rxRst,
  output logic              dmaTxRst,
  output logic              dmaRxRst,
  output logic              txEnOut,
  output logic              rxEnOut,
  output logic              dmaTxEnOut,
  output logic              txFifoIrq,
  output logic              txLoadOk,
  output logic              txIdle,
  output logic              txLine,
  output logic              abortReq,
  output logic              abortFlag
);
  ctrlStrb_t             strb;
  logic [NumRstBits-1:0] rstPulse;
  logic                  ctsForced;

  hdlc_ctrl_ctl #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)) ctl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .dmaTxEn(dmaTxEnOut),
    .txUnderrun(txUnderrun), .ctsLine(ctsLine), .nullNextDesc(nullNextDesc),
    .descOwnedByDma(descOwnedByDma), .stopOnSkip(stopOnSkip),
    .strb(strb), .abortReq(abortReq), .ctsForced(ctsForced)
  );

  hdlc_ctrl_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(wrData[CtrlBits-1:0]),
    .rdData(rdData), .rstPulse(rstPulse), .txEn(txEnOut), .rxEn(rxEnOut),
    .dmaTxEn(dmaTxEnOut), .abortFlag(abortFlag)
  );

  assign txRst     = rstPulse[BitTxRst];
  assign rxRst     = rstPulse[BitRxRst];
  assign dmaTxRst  = rstPulse[BitDmaTxRst];
  assign dmaRxRst  = rstPulse[BitDmaRxRst];
  assign txFifoIrq = txFifoAvail & ~dmaTxEnOut;
  assign txLoadOk  = txEnOut & txLoadReq;
  assign txIdle    = txEnOut & ~txDataPending & ~ctsForced;
  assign txLine    = ~txEnOut | ctsForced | txSerial;
endmodule

// File: rtl/hdlc_ctrl_chk.sv
module hdlc_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic txUnderrun,
  input logic ctsLine,
  input logic nullNextDesc,
  input logic descOwnedByDma,
  input logic stopOnSkip,
  input logic txFifoAvail,
  input logic txLoadReq,
  input logic txRst,
  input logic txEnOut,
  input logic dmaTxEnOut,
  input logic txFifoIrq,
  input logic txLoadOk,
  input logic txLine,
  input logic abortReq,
  input logic abortFlag
);
  // R3
  tx_rst_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txRst |=> !txRst);

  // R4
  tx_off_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnOut |-> (txLine && !txLoadOk));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTxEnOut && txFifoAvail) |-> !txFifoIrq);

  // R8
  dma_autoclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrun || ctsLine || nullNextDesc || (stopOnSkip && !descOwnedByDma))
      |=> !dmaTxEnOut);

  // R9
  underrun_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTxEnOut && txUnderrun) |=> (abortReq && abortFlag));

  // R9
  abort_req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);

  // R10
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaTxEnOut && ctsLine) |=> (abortFlag && (!ctsLine || txLine)));
endmodule

bind hdlc_chan_ctrl hdlc_ctrl_chk chk_i (.*);

// File: tb/hdlc_chan_ctrl_tb_top.sv
module hdlc_chan_ctrl_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam logic [AW-1:0] CO = 4'd0;
  localparam logic [AW-1:0] SO = 4'd8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic txUnderrun = 0, ctsLine = 0, nullNextDesc = 0, descOwnedByDma = 1, stopOnSkip = 0;
  logic txFifoAvail = 0, txLoadReq = 0, txDataPending = 0, txSerial = 0;
  logic txRst, rxRst, dmaTxRst, dmaRxRst, txEnOut, rxEnOut, dmaTxEnOut;
  logic txFifoIrq, txLoadOk, txIdle, txLine, abortReq, abortFlag;

  hdlc_chan_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CTRL_OFS(CO), .STAT_OFS(SO)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .txUnderrun(txUnderrun), .ctsLine(ctsLine), .nullNextDesc(nullNextDesc),
    .descOwnedByDma(descOwnedByDma), .stopOnSkip(stopOnSkip), .txFifoAvail(txFifoAvail),
    .txLoadReq(txLoadReq), .txDataPending(txDataPending), .txSerial(txSerial),
    .txRst(txRst), .rxRst(rxRst), .dmaTxRst(dmaTxRst), .dmaRxRst(dmaRxRst),
    .txEnOut(txEnOut), .rxEnOut(rxEnOut), .dmaTxEnOut(dmaTxEnOut), .txFifoIrq(txFifoIrq),
    .txLoadOk(txLoadOk), .txIdle(txIdle), .txLine(txLine), .abortReq(abortReq),
    .abortFlag(abortFlag)
  );

  int testCnt = 0;
  int failCnt = 0;

  // behavioural reference state
  bit mTx, mRx, mDma, mFlag, mHold, mAb;
  bit [3:0] mRst;

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expRead();
    int v = 0;
    if (addr == CO) v = (int'(mTx) << 4) | (int'(mRx) << 5) | (int'(mDma) << 6);
    else if (addr == SO) v = int'(mFlag);
    return v;
  endfunction

  task automatic compareAll(input string ctx);
    bit forced = mHold && ctsLine;
    chk({ctx, " R2 rdData"}, int'(rdData), expRead());
    chk({ctx, " R3 resets"}, int'({dmaRxRst, dmaTxRst, rxRst, txRst}), int'(mRst));
    chk({ctx, " R4 loadOk"}, int'(txLoadOk), int'(mTx && txLoadReq));
    chk({ctx, " R12 R10 R4 line"}, int'(txLine), int'(!mTx || forced || txSerial));
    chk({ctx, " R5 idle"}, int'(txIdle), int'(mTx && !txDataPending && !forced));
    chk({ctx, " R6 rxEn"}, int'(rxEnOut), int'(mRx));
    chk({ctx, " R7 irq"}, int'(txFifoIrq), int'(txFifoAvail && !mDma));
    chk({ctx, " R8 dmaEn"}, int'(dmaTxEnOut), int'(mDma));
    chk({ctx, " R9 abortReq"}, int'(abortReq), int'(mAb));
    chk({ctx, " R11 flag"}, int'(abortFlag), int'(mFlag));
  endtask

  // one clock: model next state from inputs present at the edge, then compare
  task automatic step(input string ctx);
    bit wC = wrEn && addr == CO;
    bit wS = wrEn && addr == SO;
    bit kill = txUnderrun || ctsLine || nullNextDesc || (stopOnSkip && !descOwnedByDma);
    bit nTx = mTx, nRx = mRx, nDma = mDma, nFlag, nHold, nAb;
    bit [3:0] nRst = '0;
    if (wC) begin nRst = wrData[3:0]; nTx = wrData[4]; nRx = wrData[5]; nDma = wrData[6]; end
    if (kill) nDma = 0;
    nFlag = (mDma && (txUnderrun || ctsLine)) || (mFlag && !(wS && wrData[0]));
    nHold = ctsLine && (mHold || mDma);
    nAb = mDma && txUnderrun;
    if (!rstN) begin nTx = 0; nRx = 0; nDma = 0; nFlag = 0; nHold = 0; nAb = 0; nRst = 0; end
    @(posedge clk);
    #2;
    mTx = nTx; mRx = nRx; mDma = nDma; mFlag = nFlag; mHold = nHold; mAb = nAb; mRst = nRst;
    compareAll(ctx);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string ctx);
    addr = a; wrData = d; wrEn = 1;
    step(ctx);
    wrEn = 0; wrData = '0;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    step("R1 reset");
    step("R1 reset");
    rstN = 1;
    chk("R1 line high", int'(txLine), 1);
    step("after reset");
    txLoadReq = 1; txSerial = 0;
    step("R4 disabled refuses load");
    // all reset bits plus enables, then only two resets
    wr(CO, 16'hFFFF, "R2 R3 write all");
    step("R3 pulse gone");
    wr(CO, 16'h0035, "R3 partial resets");
    step("R3 idle");
    txDataPending = 0;
    step("R5 idle fill");
    txDataPending = 1; txSerial = 1;
    step("R12 data 1");
    txSerial = 0;
    step("R12 data 0");
    addr = 4'd3;
    step("R2 unmapped read");
    // DMA on, irq masked
    txFifoAvail = 1;
    wr(CO, 16'h0070, "R8 enable dma");
    step("R7 masked");
    txUnderrun = 1;
    step("R9 underrun");
    txUnderrun = 0;
    step("R9 after underrun");
    addr = SO;
    step("R11 read flag");
    wr(SO, 16'h0000, "R11 write zero");
    wr(SO, 16'h0001, "R11 w1c");
    // CTS loss and hold
    wr(CO, 16'h0050, "R8 re-enable");
    txSerial = 0; txDataPending = 0;
    ctsLine = 1;
    step("R10 cts lost");
    step("R10 held high");
    step("R10 held high 2");
    ctsLine = 0;
    step("R10 released");
    // set vs clear race on flag
    wr(CO, 16'h0050, "R8 enable");
    txUnderrun = 1;
    wr(SO, 16'h0001, "R11 set wins");
    txUnderrun = 0;
    step("R11 after race");
    wr(SO, 16'h0001, "R11 clear");
    // remaining auto-clear causes
    wr(CO, 16'h0050, "R8 enable");
    nullNextDesc = 1;
    step("R8 null pointer");
    nullNextDesc = 0;
    wr(CO, 16'h0050, "R8 enable");
    descOwnedByDma = 0; stopOnSkip = 0;
    step("R8 skip without stop");
    stopOnSkip = 1;
    step("R8 skip with stop");
    descOwnedByDma = 1; stopOnSkip = 0;
    // write that sets enable loses to same-cycle clear
    nullNextDesc = 1;
    wr(CO, 16'h0050, "R8 clear wins");
    nullNextDesc = 0;
    step("R8 after race");
    wr(CO, 16'h0000, "R4 disable all");
    txSerial = 0;
    step("R4 line high when off");
    rstN = 0;
    step("R1 reset again");
    rstN = 1;
    step("R1 out of reset");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule